// File: doc/BRIEF.md
# Scale-Accumulate Saturating Datapath

This block is an 8-bit arithmetic stage that sits on a shared data bus. A controller steps it with three strobes. The rising edge of `add_i` captures whatever value is on the bus. `go_i` computes a result from the captured operands and drives it onto the bus through an output enable. `stop_i` wipes the held operands, the result and the enable.

The operation depends on how many captures arrived before `go_i` and on the `sharpen_i` input. With one capture and sharpen low, the value is passed through untouched. With two or more captures, the first operand is scaled by the unsigned fixed-point factor `scale_i`, where 8'h80 means 1.0. The scaled value is added to the latest second operand, and the sum clamps at 8'hFF. With sharpen high, the most recent capture is read as a signed number. It is kept only if its magnitude is strictly larger than `scale_i`; otherwise the block outputs zero.

The bus is modelled as a separate input, a separate output and an output enable, so a pad or a wrapper can build the tri-state driver.

Top module: `scale_acc_unit`

## Requirements
- R1: After reset, `bus_oe_o` is 0, `bus_o` is 0 and no operands are held.
- R2: A capture happens only on a rising edge of `add_i` (high in this cycle, low in the previous one). Holding `add_i` high for several cycles captures once, taking the bus value of the first high cycle.
- R3: With exactly one capture and `sharpen_i` low, the result equals the captured value.
- R4: With two captures and `sharpen_i` low, the result is floor(A*scale/128)+B. A is the first capture and B is the second; for example, 20 with scale 8'h40 added to 40 gives 50.
- R5: When that sum exceeds 255, the result is 8'hFF.
- R6: Each capture after the second replaces B; A keeps the first capture.
- R7: With `sharpen_i` high, let V be the most recent capture read as two's complement. The result is V when |V| > `scale_i` and 0 otherwise, including when |V| equals `scale_i`. For V = 8'h80, |V| is 128.
- R8: In each cycle `go_i` is high, the result is registered from the current operands, `sharpen_i` and `scale_i`. From the next cycle, `bus_oe_o` is 1 and `bus_o` shows that result. After `go_i` falls, `bus_o` holds until the next `go_i` or `stop_i`, even if new captures arrive.
- R9: A cycle with `stop_i` high clears the operands, the capture count, the result and `bus_oe_o`. In that cycle, `stop_i` overrides both a rising `add_i` and `go_i`.
- R10: With no captures held, `go_i` yields a result of 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| add_i | input | 1 | Capture strobe; rising edge captures the bus |
| go_i | input | 1 | Compute and drive result |
| stop_i | input | 1 | Clear all held state |
| sharpen_i | input | 1 | Selects threshold gating |
| scale_i | input | 8 | Scale factor (8'h80 = 1.0) or threshold |
| bus_i | input | 8 | Value present on the shared bus |
| bus_o | output | 8 | Result to drive onto the bus |
| bus_oe_o | output | 1 | Bus output enable |

## Verification
The collision of interest is `stop_i` arriving in the same cycle as a rising `add_i` or as `go_i`. The bench raises `stop_i` together with a capture edge, then issues `go_i` alone; a result of 0 shows the capture was discarded. It also raises `stop_i` together with `go_i` and expects the enable to stay low with a zero result. Random rounds open with a stop and then mix capture counts, modes and scales against a bench-side arithmetic model.

// File: rtl/sac_pkg.sv
package sac_pkg;
  localparam int DATA_W = 8;
  localparam int FRAC_W = 7;

  typedef enum logic [1:0] {
    OPS_NONE = 2'd0,
    OPS_ONE  = 2'd1,
    OPS_TWO  = 2'd2
  } ops_e;
endpackage

// File: rtl/sac_capture.sv
module sac_capture
  import sac_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_i,
  input  logic          stop_i,
  input  logic [DW-1:0] bus_i,
  output ops_e          cnt_o,
  output logic [DW-1:0] op_a_o,
  output logic [DW-1:0] op_b_o,
  output logic [DW-1:0] last_o,
  output logic          add_rise_o
);
  logic          add_q;
  ops_e          cnt_q;
  logic [DW-1:0] op_a_q;
  logic [DW-1:0] op_b_q;
  logic [DW-1:0] last_q;

  assign add_rise_o = add_i & ~add_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      add_q  <= 1'b0;
      cnt_q  <= OPS_NONE;
      op_a_q <= '0;
      op_b_q <= '0;
      last_q <= '0;
    end else begin
      add_q <= add_i;
      if (stop_i) begin
        cnt_q  <= OPS_NONE;
        op_a_q <= '0;
        op_b_q <= '0;
        last_q <= '0;
      end else if (add_rise_o) begin
        last_q <= bus_i;
        if (cnt_q == OPS_NONE) begin
          op_a_q <= bus_i;
          cnt_q  <= OPS_ONE;
        end else begin
          op_b_q <= bus_i;
          cnt_q  <= OPS_TWO;
        end
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign op_a_o = op_a_q;
  assign op_b_o = op_b_q;
  assign last_o = last_q;

  AST_CAPTURE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (add_rise_o && !stop_i) |=> (cnt_q != OPS_NONE) && (last_q == $past(bus_i))); // R2
  AST_NO_EDGE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_rise_o && !stop_i) |=> $stable(cnt_q) && $stable(op_a_q) && $stable(op_b_q)); // R2
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (add_rise_o && !stop_i && cnt_q != OPS_NONE) |=> $stable(op_a_q)); // R6
  AST_STOP_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (cnt_q == OPS_NONE) && (last_q == '0)); // R9
endmodule

// File: rtl/sac_compute.sv
module sac_compute
  import sac_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int FRAC = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ops_e          cnt_i,
  input  logic [DW-1:0] op_a_i,
  input  logic [DW-1:0] op_b_i,
  input  logic [DW-1:0] last_i,
  input  logic          sharpen_i,
  input  logic [DW-1:0] scale_i,
  output logic [DW-1:0] res_o
);
  localparam int PW = 2 * DW;

  function automatic logic [DW-1:0] scale_add_sat(input logic [DW-1:0] a,
                                                  input logic [DW-1:0] b,
                                                  input logic [DW-1:0] s);
    logic [PW-1:0] prod;
    logic [PW:0]   sum;
    prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, s};
    sum  = {1'b0, prod >> FRAC} + {{(PW+1-DW){1'b0}}, b};
    if (sum > {{(PW+1-DW){1'b0}}, {DW{1'b1}}}) return {DW{1'b1}};
    return sum[DW-1:0];
  endfunction

  function automatic logic [DW:0] mag_of(input logic [DW-1:0] v);
    logic [DW:0] ext;
    ext = {v[DW-1], v};
    return v[DW-1] ? (~ext + 1'b1) : ext;
  endfunction

  function automatic logic [DW-1:0] gate(input logic [DW-1:0] v,
                                         input logic [DW-1:0] s);
    return (mag_of(v) > {1'b0, s}) ? v : '0;
  endfunction

  always_comb begin
    res_o = '0;
    if (cnt_i != OPS_NONE) begin
      if (sharpen_i)               res_o = gate(last_i, scale_i);
      else if (cnt_i == OPS_ONE)   res_o = op_a_i;
      else                         res_o = scale_add_sat(op_a_i, op_b_i, scale_i);
    end
  end

  AST_GATE_PASS_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sharpen_i && cnt_i != OPS_NONE) |-> (res_o == '0 || res_o == last_i)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!sharpen_i && cnt_i == OPS_TWO) |-> (res_o >= op_b_i)); // R5
  AST_PASS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sharpen_i && cnt_i == OPS_ONE) |-> (res_o == op_a_i)); // R3
endmodule

// File: rtl/sac_bus_drv.sv
module sac_bus_drv
  import sac_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic          stop_i,
  input  logic [DW-1:0] res_i,
  output logic [DW-1:0] bus_o,
  output logic          oe_o
);
  logic [DW-1:0] res_q;
  logic          oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      oe_q  <= 1'b0;
    end else if (stop_i) begin
      res_q <= '0;
      oe_q  <= 1'b0;
    end else if (go_i) begin
      res_q <= res_i;
      oe_q  <= 1'b1;
    end
  end

  assign bus_o = res_q & {DW{oe_q}};
  assign oe_o  = oe_q;

  AST_GO_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !stop_i) |=> oe_q && (bus_o == $past(res_i))); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_i && !stop_i) |=> $stable(bus_o)); // R8
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !oe_q && (bus_o == '0)); // R9
endmodule

// File: rtl/scale_acc_unit.sv
module scale_acc_unit
  import sac_pkg::*;
#(
  parameter int DW   = DATA_W,
  parameter int FRAC = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          add_i,
  input  logic          go_i,
  input  logic          stop_i,
  input  logic          sharpen_i,
  input  logic [DW-1:0] scale_i,
  input  logic [DW-1:0] bus_i,
  output logic [DW-1:0] bus_o,
  output logic          bus_oe_o
);
  ops_e          cnt_w;
  logic [DW-1:0] op_a_w;
  logic [DW-1:0] op_b_w;
  logic [DW-1:0] last_w;
  logic          add_rise_w;
  logic [DW-1:0] res_w;

  sac_capture #(.DW(DW)) u_capture (
    .clk(clk), .rst_n(rst_n), .add_i(add_i), .stop_i(stop_i), .bus_i(bus_i),
    .cnt_o(cnt_w), .op_a_o(op_a_w), .op_b_o(op_b_w), .last_o(last_w),
    .add_rise_o(add_rise_w)
  );

  sac_compute #(.DW(DW), .FRAC(FRAC)) u_compute (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_w), .op_a_i(op_a_w), .op_b_i(op_b_w),
    .last_i(last_w), .sharpen_i(sharpen_i), .scale_i(scale_i), .res_o(res_w)
  );

  sac_bus_drv #(.DW(DW)) u_bus (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .stop_i(stop_i), .res_i(res_w),
    .bus_o(bus_o), .oe_o(bus_oe_o)
  );

  AST_EMPTY_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_w == OPS_NONE && go_i && !stop_i) |=> (bus_o == '0)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> !bus_oe_o && (bus_o == '0)); // R1
endmodule

// File: tb/scale_acc_unit_tb.sv
`timescale 1ns/1ps
module scale_acc_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       add_i = 1'b0, go_i = 1'b0, stop_i = 1'b0, sharpen_i = 1'b0;
  logic [7:0] scale_i = 8'h80, bus_i = 8'h00;
  logic [7:0] bus_o;
  logic       bus_oe_o;

  int checks = 0;
  int errors = 0;

  int         m_n = 0;
  logic [7:0] m_a = 0, m_b = 0, m_last = 0;
  logic [7:0] m_out = 0;

  always #4 clk = ~clk;

  scale_acc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .add_i(add_i), .go_i(go_i), .stop_i(stop_i),
    .sharpen_i(sharpen_i), .scale_i(scale_i), .bus_i(bus_i),
    .bus_o(bus_o), .bus_oe_o(bus_oe_o)
  );

  function automatic logic [7:0] model(int n, logic [7:0] a, logic [7:0] b,
                                       logic [7:0] last, bit sh, logic [7:0] s);
    int sv, m, t;
    if (n == 0) return 8'h00;
    if (sh) begin
      sv = (int'(last) > 127) ? int'(last) - 256 : int'(last);
      m  = (sv < 0) ? -sv : sv;
      return (m > int'(s)) ? last : 8'h00;
    end
    if (n == 1) return a;
    t = (int'(a) * int'(s)) / 128 + int'(b);
    return (t > 255) ? 8'hFF : t[7:0];
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_add(logic [7:0] v);
    @(negedge clk); bus_i = v; add_i = 1'b1;
    @(negedge clk); add_i = 1'b0;
    m_last = v;
    if (m_n == 0) begin m_a = v; m_n = 1; end
    else begin m_b = v; m_n = 2; end
  endtask

  task automatic do_stop();
    @(negedge clk); stop_i = 1'b1;
    @(negedge clk); stop_i = 1'b0;
    m_n = 0; m_a = 0; m_b = 0; m_last = 0; m_out = 0;
  endtask

  task automatic do_go(string tag);
    @(negedge clk); go_i = 1'b1;
    m_out = model(m_n, m_a, m_b, m_last, sharpen_i, scale_i);
    @(negedge clk); go_i = 1'b0;
    check({tag, " oe"}, {7'd0, bus_oe_o}, 8'h01);
    check({tag, " data"}, bus_o, m_out);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset oe", {7'd0, bus_oe_o}, 8'h00);
    check("R1 reset data", bus_o, 8'h00);

    sharpen_i = 0; scale_i = 8'h40;
    do_go("R10 empty plain");
    sharpen_i = 1;
    do_go("R10 empty sharpen");
    sharpen_i = 0;

    do_stop();
    check("R9 stop oe", {7'd0, bus_oe_o}, 8'h00);
    do_add(8'd40);
    do_go("R3 pass 40");
    do_stop();
    do_add(8'd20); do_add(8'd40);
    do_go("R4 half scale 20+40");
    check("R4 value 50", bus_o, 8'd50);
    do_stop(); scale_i = 8'hFF;
    do_add(8'hFF); do_add(8'hFF);
    do_go("R5 saturate");
    check("R5 value FF", bus_o, 8'hFF);
    do_stop(); scale_i = 8'h80;
    do_add(8'd10); do_add(8'd1); do_add(8'd2); do_add(8'd7);
    do_go("R6 overwrite B");
    check("R6 value 17", bus_o, 8'd17);

    // R8 hold after go falls
    do_add(8'd99);
    @(negedge clk);
    check("R8 hold oe", {7'd0, bus_oe_o}, 8'h01);
    check("R8 hold data", bus_o, 8'd17);

    // R2 held add captures first value only
    do_stop();
    @(negedge clk); bus_i = 8'd33; add_i = 1'b1;
    @(negedge clk); bus_i = 8'd44;
    @(negedge clk); bus_i = 8'd55;
    @(negedge clk); add_i = 1'b0;
    m_n = 1; m_a = 8'd33; m_last = 8'd33;
    do_go("R2 held add");

    // R7 threshold corners
    sharpen_i = 1; scale_i = 8'd5;
    do_stop(); do_add(8'd5);   do_go("R7 equal pos zero");
    do_stop(); do_add(8'd6);   do_go("R7 above pos");
    do_stop(); do_add(8'hFA);  do_go("R7 neg above");
    do_stop(); do_add(8'hFB);  do_go("R7 neg equal zero");
    scale_i = 8'd127;
    do_stop(); do_add(8'h80);  do_go("R7 most negative");
    scale_i = 8'd128;
    do_stop(); do_add(8'h80);  do_go("R7 most negative equal");
    scale_i = 8'd3;
    do_stop(); do_add(8'd1); do_add(8'hF0); do_go("R7 latest value");
    sharpen_i = 0;

    // R9 stop with add in same cycle
    do_stop();
    @(negedge clk); stop_i = 1'b1; add_i = 1'b1; bus_i = 8'd77;
    @(negedge clk); stop_i = 1'b0; add_i = 1'b0;
    m_n = 0;
    do_go("R9 stop beats add");
    // R9 stop with go in same cycle
    do_add(8'd12);
    @(negedge clk); stop_i = 1'b1; go_i = 1'b1;
    @(negedge clk); stop_i = 1'b0; go_i = 1'b0;
    m_n = 0; m_a = 0; m_b = 0; m_last = 0;
    check("R9 stop beats go oe", {7'd0, bus_oe_o}, 8'h00);
    check("R9 stop beats go data", bus_o, 8'h00);

    // random rounds
    for (int i = 0; i < 300; i++) begin
      int n;
      do_stop();
      n = $urandom_range(0, 3);
      sharpen_i = ($urandom_range(0, 3) == 0);
      scale_i = $urandom_range(0, 255);
      for (int k = 0; k < n; k++) do_add($urandom_range(0, 255));
      if (sharpen_i) do_go("R7 random");
      else if (n >= 2) do_go("R4 random");
      else if (n == 1) do_go("R3 random");
      else do_go("R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule